// File: doc/BRIEF.md
# UART Modem Status and Loopback Register Pair

This block holds the modem control and modem status registers of a classic single-channel UART. It also raises that UART's modem-status interrupt request. A small register port with an 8-bit data bus and a 3-bit offset reads and writes both registers. Writes and read side effects take effect at the clock edge that ends the access.

In normal operation the four status bits of the status register track the external CTS, DSR, RI and DCD pins. Each pin passes through a two-flop synchronizer first. When the loop bit of the control register is set, the external pins are ignored. The status bits are then fed from the control register's own output bits. This lets software test the modem handshake path without a cable.

Each time the status bits are evaluated, the block compares the new status with the value held in the register. Any change sets a sticky change flag. For RI, only a falling edge sets its flag. Reading the status register returns its contents and then clears it. The block then re-evaluates the register against the cleared value, so a control setting that is still looped back shows up again at once.

Top module: `uart_modem_regs`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00 and `msi_irq` is low.
- R2: A write at offset 4 stores data bits 4:0 in the control register: bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loop enable. A read at offset 4 returns them with bits 7:5 as zero.
- R3: While the loop enable is 1, the status bits are: bit4 (CTS) = RTS, bit5 (DSR) = DTR, bit6 (RI) = OUT1, bit7 (DCD) = OUT2. The external pins have no effect.
- R4: A control write updates the status bits and change flags at the same clock edge that stores the write, so they are readable in the very next cycle.
- R5: Status bit 0 (CTS changed), bit 1 (DSR changed) and bit 3 (DCD changed) are set when the new CTS, DSR or DCD value differs from the value currently held in the status register.
- R6: Status bit 2 (RI trailing edge) is set only when the held RI is 1 and the new RI is 0. A rising RI does not set it.
- R7: Change flags are sticky. They stay set until a status read, and later changes OR into them.
- R8: A read at offset 6 with `rd_en` high returns the current status byte. At that edge the register is cleared and re-evaluated against zero. Afterwards the three changed flags equal their status bits and the RI flag is 0.
- R9: `msi_irq` is high exactly when any of status bits 3:0 is set.
- R10: With loop enable 0, a pin change present before edge k appears in the status register after edge k+2.
- R11: Writes to offset 6 and to offsets other than 4 leave both registers unchanged. Reads at offsets other than 4 and 6 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; enables the status-read side effect |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the offset |
| cts_in | input | 1 | External clear-to-send pin, active high |
| dsr_in | input | 1 | External data-set-ready pin, active high |
| ri_in | input | 1 | External ring-indicator pin, active high |
| dcd_in | input | 1 | External carrier-detect pin, active high |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
The embedded properties take for granted that `addr`, `wr_en`, `rd_en` and the modem pins are never unknown. They also assume that a status read and a control write do not coincide in ways that matter for stickiness: the stickiness property simply exempts cycles that carry a status read. The stimulus drives every strobe for exactly one cycle from the falling edge and keeps both strobes apart. It changes the external pins only at falling edges. Inspections of the status byte use the offset alone with `rd_en` low, so that looking at the register never clears it.

// File: rtl/uart_modem_regs.sv
module uart_modem_regs #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter logic [AW-1:0] MCR_OFS = 3'd4,
  parameter logic [AW-1:0] MSR_OFS = 3'd6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cts_in,
  input  logic          dsr_in,
  input  logic          ri_in,
  input  logic          dcd_in,
  output logic          msi_irq
);

  logic [4:0] mcr_q, mcr_nx;
  logic [7:0] msr_q, msr_nx, held;
  logic [3:0] pin_s1, pin_s2, src;
  logic [3:0] dflag;
  logic       wr_mcr, rd_msr;

  assign wr_mcr = wr_en && (addr == MCR_OFS);
  assign rd_msr = rd_en && (addr == MSR_OFS);
  assign mcr_nx = wr_mcr ? wdata[4:0] : mcr_q;

  // status source order [3:0] = {dcd, ri, dsr, cts}
  assign src  = mcr_nx[4] ? {mcr_nx[3], mcr_nx[2], mcr_nx[0], mcr_nx[1]} : pin_s2;
  assign held = rd_msr ? 8'h00 : msr_q;

  assign dflag[0] = held[0] | (src[0] ^ held[4]);
  assign dflag[1] = held[1] | (src[1] ^ held[5]);
  assign dflag[2] = held[2] | (held[6] & ~src[2]);
  assign dflag[3] = held[3] | (src[3] ^ held[7]);
  assign msr_nx   = {src, dflag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
      mcr_q  <= '0;
      msr_q  <= '0;
    end else begin
      pin_s1 <= {dcd_in, ri_in, dsr_in, cts_in};
      pin_s2 <= pin_s1;
      mcr_q  <= mcr_nx;
      msr_q  <= msr_nx;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == MCR_OFS)      rdata = {{(DW-5){1'b0}}, mcr_q};
    else if (addr == MSR_OFS) rdata = msr_q;
  end

  assign msi_irq = |msr_q[3:0];

  assert_mcr_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mcr |=> (mcr_q == $past(wdata[4:0])));

  assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mcr_q[4] |-> (msr_q[7:4] == {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]}));

  assert_ri_trailing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_q[2]) |-> ($past(msr_q[6]) && !msr_q[6]));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_msr |=> ((msr_q[3:0] & $past(msr_q[3:0])) == $past(msr_q[3:0])));

  assert_read_reeval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_msr |=> (!msr_q[2] && msr_q[0] == msr_q[4] && msr_q[1] == msr_q[5]
                && msr_q[3] == msr_q[7]));

endmodule

// File: tb/uart_modem_regs_tb.sv
module uart_modem_regs_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0;
  logic       msi_irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_modem_regs u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cts_in(cts_in), .dsr_in(dsr_in),
    .ri_in(ri_in), .dcd_in(dcd_in), .msi_irq(msi_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_msr(output logic [7:0] d);
    @(negedge clk); addr = 3'd6; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(3'd4, v); chk("R1 mcr", v, 8'h00);
    peek(3'd6, v); chk("R1 msr", v, 8'h00);
    chk("R1 irq", {7'd0, msi_irq}, 8'h00);
  endtask

  task automatic t_mask_and_loop_all();
    logic [7:0] v;
    wr(3'd4, 8'hFF);
    peek(3'd4, v); chk("R2 mask", v, 8'h1F);
    peek(3'd6, v); chk("R3 R4 R5 loop all", v, 8'hFB);
    chk("R9 irq set", {7'd0, msi_irq}, 8'h01);
    rd_msr(v); chk("R8 read value", v, 8'hFB);
    peek(3'd6, v); chk("R8 reeval", v, 8'hFB);
  endtask

  task automatic t_trailing_edge();
    logic [7:0] v;
    wr(3'd4, 8'h10);
    peek(3'd6, v); chk("R6 ri falls", v, 8'h0F);
    rd_msr(v); chk("R8 read", v, 8'h0F);
    peek(3'd6, v); chk("R8 cleared", v, 8'h00);
    chk("R9 irq clear", {7'd0, msi_irq}, 8'h00);
    wr(3'd4, 8'h14);
    peek(3'd6, v); chk("R6 ri rise no flag", v, 8'h40);
    chk("R9 irq low", {7'd0, msi_irq}, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    wr(3'd4, 8'h15);
    peek(3'd6, v); chk("R5 dsr", v, 8'h62);
    wr(3'd4, 8'h10);
    peek(3'd6, v); chk("R7 sticky", v, 8'h06);
    rd_msr(v); chk("R8 read", v, 8'h06);
  endtask

  task automatic t_map_individual();
    logic [7:0] v;
    wr(3'd4, 8'h12);
    peek(3'd6, v); chk("R3 rts->cts", v, 8'h11);
    cts_in = 1; dsr_in = 1; dcd_in = 1;
    repeat (4) @(negedge clk);
    peek(3'd6, v); chk("R3 pins ignored", v, 8'h11);
    cts_in = 0; dsr_in = 0; dcd_in = 0;
    repeat (4) @(negedge clk);
    rd_msr(v);
    wr(3'd4, 8'h18);
    peek(3'd6, v); chk("R3 out2->dcd", v, 8'h89);
    rd_msr(v); chk("R8 read", v, 8'h89);
    peek(3'd6, v); chk("R8 reeval", v, 8'h88);
    wr(3'd4, 8'h00);
    peek(3'd6, v); chk("R5 leave loop", v, 8'h08);
    rd_msr(v);
    peek(3'd6, v); chk("R8 normal clear", v, 8'h00);
  endtask

  task automatic t_normal();
    logic [7:0] v;
    @(negedge clk); cts_in = 1;
    @(negedge clk); @(negedge clk);
    #1 chk("R10 not yet", rdata, 8'h00);
    @(negedge clk); #1 chk("R10 cts", rdata, 8'h11);
    chk("R9 irq", {7'd0, msi_irq}, 8'h01);
    ri_in = 1; repeat (3) @(negedge clk);
    peek(3'd6, v); chk("R10 ri", v, 8'h51);
    ri_in = 0; repeat (3) @(negedge clk);
    peek(3'd6, v); chk("R6 ri trailing pin", v, 8'h15);
    rd_msr(v); chk("R8 read", v, 8'h15);
    peek(3'd6, v); chk("R8 reeval normal", v, 8'h11);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr(3'd6, 8'hFF);
    peek(3'd6, v); chk("R11 msr write", v, 8'h11);
    wr(3'd3, 8'h1F);
    peek(3'd4, v); chk("R11 other write", v, 8'h00);
    peek(3'd0, v); chk("R11 other read", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mask_and_loop_all();
    t_trailing_edge();
    t_sticky();
    t_map_individual();
    t_normal();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule